// File: doc/BRIEF.md
# 16-bit Multicycle Processor Core

This block is a small 16-bit processor core that runs each instruction over several clock cycles. It uses one memory port for both instruction fetches and data accesses. A Moore control state machine steers a shared datapath. That datapath holds the following registers:

- program counter
- instruction register
- memory data register
- two operand latches
- ALU result register
- a 16-entry register file

Each cycle performs one step of the current instruction: fetch, decode, address or operand calculation, memory access, or writeback.

Instructions are 16 bits wide and split into four 4-bit fields. The opcode sits in bits 15..12, the first source register in bits 11..8 and the second source register in bits 7..4. Bits 3..0 hold either the destination register (for register-to-register operations) or a signed 4-bit immediate.

The surrounding system attaches a word-addressed memory. Writes take effect at a clock edge. Reads are combinational on `mem_addr`, so `mem_rdata` must be valid in the same cycle the address is driven.

Top module: `mc16_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and puts the control in the fetch step. While reset is held, and in the first cycle after it, `mem_addr` is 0 and `mem_we` is 0.
- R2: Every instruction begins with the same two cycles:
  - a fetch cycle, which drives the program counter on `mem_addr` and loads the instruction;
  - a decode cycle, in which `mem_addr` shows the program counter already advanced by one.
- R3: Opcodes 0 to 4 are register operations. They compute rs op rt with opcode 0 = add, 1 = and, 2 = or, 3 = subtract (rs minus rt), 4 = signed set-less-than (result 1 or 0). Each takes four cycles and writes the result to the register named in bits 3..0.
- R4: Opcode 8 is a load of rt from address rs + sign-extended imm4. It takes five cycles, and the fourth cycle drives that address on `mem_addr`.
- R5: Opcode 9 is a store of rt to address rs + sign-extended imm4. It takes four cycles. The fourth cycle drives the address, `mem_we` = 1 and `mem_wdata` = rt.
- R6: Opcode 10 is branch-if-equal and takes three cycles. When rs equals rt, the next program counter is PC+1+sext(imm4); otherwise it is PC+1.
- R7: Opcode 11 is a jump and takes three cycles. The next program counter is formed from bits 15..12 of PC+1 followed by instruction bits 11..0.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: Opcodes 5, 6, 7 and 12 to 15 end after the decode cycle, two cycles in total. They change no register and no memory word.
- R10: Outside the data-access cycle of a load or store, `mem_addr` equals the program counter and `mem_we` is 0. `mem_we` is 1 only in the access cycle of a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address for fetch or data access |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Read data for `mem_addr`, valid in the same cycle |

## Verification
Any wrong internal state shows up on the memory port almost at once:

- A mis-decoded opcode or a wrong step order changes the length of an instruction. The next fetch address then appears one or more cycles off, within that same instruction.
- A wrong program counter update (branch, jump or increment) shows as a wrong `mem_addr` in the very next fetch cycle.
- A corrupted register value appears at the latest when that register forms a load or store address, or is stored and its data is seen on `mem_wdata`.

The bench therefore compares the address, write strobe and store data on every cycle. It also checks the stored result words once the program has finished.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  localparam int DW   = 16;
  localparam int RAW  = 4;
  localparam int OPW  = 4;
  localparam int IMMW = 4;
  localparam int JW   = 12;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MEMADR, S_MEMRD, S_MEMWB,
    S_MEMWR, S_EXEC, S_RWB, S_BRANCH, S_JUMP
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_AND = 3'd1, ALU_OR = 3'd2, ALU_SUB = 3'd3, ALU_SLT = 3'd4
  } alu_op_t;

  typedef enum logic [1:0] {
    SRCB_REG = 2'd0, SRCB_ONE = 2'd1, SRCB_IMM = 2'd2, SRCB_IMM_ALT = 2'd3
  } srcb_t;

  typedef enum logic [1:0] {
    PCS_ALU = 2'd0, PCS_ALUREG = 2'd1, PCS_JUMP = 2'd2, PCS_HOLD = 2'd3
  } pcsrc_t;

  localparam logic [OPW-1:0] OP_RMAX = 4'd4;
  localparam logic [OPW-1:0] OP_LD   = 4'd8;
  localparam logic [OPW-1:0] OP_ST   = 4'd9;
  localparam logic [OPW-1:0] OP_BEQ  = 4'd10;
  localparam logic [OPW-1:0] OP_JMP  = 4'd11;

  typedef struct packed {
    logic    pc_write;
    logic    pc_write_cond;
    logic    addr_from_alu;
    logic    mem_write;
    logic    ir_write;
    logic    dst_is_rd;
    logic    wb_from_mdr;
    logic    reg_write;
    logic    srca_reg;
    srcb_t   srcb;
    alu_op_t alu_op;
    pcsrc_t  pc_src;
  } ctrl_t;

endpackage

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_t      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  localparam int NREG = 1 << AW;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output ctrl_t          c,
  output state_t         state
);

  state_t nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    c   = '0;
    nxt = S_FETCH;
    case (state)
      S_FETCH: begin
        c.ir_write = 1'b1;
        c.srcb     = SRCB_ONE;
        c.pc_write = 1'b1;
        c.pc_src   = PCS_ALU;
        nxt        = S_DECODE;
      end
      S_DECODE: begin
        c.srcb = SRCB_IMM;
        if (opcode <= OP_RMAX)                      nxt = S_EXEC;
        else if (opcode == OP_LD || opcode == OP_ST) nxt = S_MEMADR;
        else if (opcode == OP_BEQ)                   nxt = S_BRANCH;
        else if (opcode == OP_JMP)                   nxt = S_JUMP;
        else                                         nxt = S_FETCH;
      end
      S_MEMADR: begin
        c.srca_reg = 1'b1;
        c.srcb     = SRCB_IMM;
        nxt        = (opcode == OP_LD) ? S_MEMRD : S_MEMWR;
      end
      S_MEMRD: begin
        c.addr_from_alu = 1'b1;
        nxt             = S_MEMWB;
      end
      S_MEMWB: begin
        c.reg_write   = 1'b1;
        c.wb_from_mdr = 1'b1;
      end
      S_MEMWR: begin
        c.addr_from_alu = 1'b1;
        c.mem_write     = 1'b1;
      end
      S_EXEC: begin
        c.srca_reg = 1'b1;
        c.srcb     = SRCB_REG;
        c.alu_op   = alu_op_t'(opcode[2:0]);
        nxt        = S_RWB;
      end
      S_RWB: begin
        c.dst_is_rd = 1'b1;
        c.reg_write = 1'b1;
      end
      S_BRANCH: begin
        c.srca_reg      = 1'b1;
        c.srcb          = SRCB_REG;
        c.alu_op        = ALU_SUB;
        c.pc_write_cond = 1'b1;
        c.pc_src        = PCS_ALUREG;
      end
      S_JUMP: begin
        c.pc_write = 1'b1;
        c.pc_src   = PCS_JUMP;
      end
      default: nxt = S_FETCH;
    endcase
  end

  assert_decode_follows_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (state == S_DECODE));

  assert_load_reaches_writeback_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_MEMRD) |=> (state == S_MEMWB));

  assert_store_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    c.mem_write |=> (state == S_FETCH));

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata
);

  localparam int PAGEW = W - JW;

  logic [W-1:0] pc, ir, mdr, a_q, b_q, alu_q;
  logic [W-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, imm_ext, jtarget, pc_next, wb_data;
  logic [RAW-1:0] wb_addr;
  logic alu_zero, pc_load;
  ctrl_t  c;
  state_t st;

  mc16_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(ir[W-1 -: OPW]), .c(c), .state(st)
  );

  mc16_regfile #(.W(W), .AW(RAW)) u_rf (
    .clk(clk), .we(c.reg_write), .waddr(wb_addr), .wdata(wb_data),
    .raddr_a(ir[11:8]), .raddr_b(ir[7:4]), .rdata_a(rf_a), .rdata_b(rf_b)
  );

  mc16_alu #(.W(W)) u_alu (
    .a(alu_a), .b(alu_b), .op(c.alu_op), .y(alu_y), .zero(alu_zero)
  );

  assign imm_ext = {{(W-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};
  assign jtarget = {pc[W-1 -: PAGEW], ir[JW-1:0]};
  assign alu_a   = c.srca_reg ? a_q : pc;

  always_comb begin
    case (c.srcb)
      SRCB_REG: alu_b = b_q;
      SRCB_ONE: alu_b = W'(1);
      default:  alu_b = imm_ext;
    endcase
  end

  always_comb begin
    case (c.pc_src)
      PCS_ALU:    pc_next = alu_y;
      PCS_ALUREG: pc_next = alu_q;
      PCS_JUMP:   pc_next = jtarget;
      default:    pc_next = pc;
    endcase
  end

  assign pc_load = c.pc_write | (c.pc_write_cond & alu_zero);
  assign wb_addr = c.dst_is_rd ? ir[3:0] : ir[7:4];
  assign wb_data = c.wb_from_mdr ? mdr : alu_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir    <= '0;
      mdr   <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
    end else begin
      if (pc_load)    pc <= pc_next;
      if (c.ir_write) ir <= mem_rdata;
      mdr   <= mem_rdata;
      a_q   <= rf_a;
      b_q   <= rf_b;
      alu_q <= alu_y;
    end
  end

  assign mem_addr  = c.addr_from_alu ? alu_q : pc;
  assign mem_wdata = b_q;
  assign mem_we    = c.mem_write;

  assert_reset_clears_pc_R1: assert property (@(posedge clk)
    rst |=> (pc == '0));

  assert_pc_advances_on_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (pc == $past(pc) + W'(1)));

  assert_branch_not_taken_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_BRANCH && !alu_zero) |=> (pc == $past(pc)));

  assert_jump_keeps_page_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_JUMP) |=> (pc[W-1 -: PAGEW] == $past(pc[W-1 -: PAGEW])));

endmodule

// File: tb/mc16_core_bench.sv
`timescale 1ns/1ps
module mc16_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mc16_core u_mc16_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  logic [15:0] mem  [0:255];
  logic [15:0] rmem [0:255];
  logic [15:0] rreg [0:15];
  logic [15:0] rpc;
  logic [32:0] expq [$];
  string       tagq [$];

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input bit we, input logic [15:0] a, input logic [15:0] d, input string tag);
    expq.push_back({we, a, d});
    tagq.push_back(tag);
  endtask

  function automatic logic [15:0] sx(input logic [3:0] v);
    return {{12{v[3]}}, v};
  endfunction

  task automatic step_model();
    logic [15:0] ins, p1, x, y, res, ea;
    logic [3:0]  op, rs, rt, lo;
    ins = rmem[rpc[7:0]];
    op = ins[15:12]; rs = ins[11:8]; rt = ins[7:4]; lo = ins[3:0];
    p1 = rpc + 16'd1;
    x  = rreg[rs]; y = rreg[rt];
    ea = x + sx(lo);
    push(1'b0, rpc, 16'h0, "R2 fetch");
    push(1'b0, p1,  16'h0, "R2 decode");
    rpc = p1;
    if (op <= 4'd4) begin
      case (op)
        4'd0: res = x + y;
        4'd1: res = x & y;
        4'd2: res = x | y;
        4'd3: res = x - y;
        default: res = ($signed(x) < $signed(y)) ? 16'd1 : 16'd0;
      endcase
      push(1'b0, p1, 16'h0, "R3 exec");
      push(1'b0, p1, 16'h0, "R3 writeback");
      if (lo != 4'd0) rreg[lo] = res;
    end else if (op == 4'd8) begin
      push(1'b0, p1, 16'h0, "R4 address");
      push(1'b0, ea, 16'h0, "R4 read");
      push(1'b0, p1, 16'h0, "R4 writeback");
      if (rt != 4'd0) rreg[rt] = rmem[ea[7:0]];
    end else if (op == 4'd9) begin
      push(1'b0, p1, 16'h0, "R5 address");
      push(1'b1, ea, y, "R5 store");
      rmem[ea[7:0]] = y;
    end else if (op == 4'd10) begin
      push(1'b0, p1, 16'h0, "R6 compare");
      if (x == y) rpc = p1 + sx(lo);
    end else if (op == 4'd11) begin
      push(1'b0, p1, 16'h0, "R7 jump");
      rpc = {p1[15:12], ins[11:0]};
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic [32:0] e;
    string t;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0]  = 16'h8018; mem[1]  = 16'h8029; mem[2]  = 16'h803A; mem[3]  = 16'h80AB;
    mem[4]  = 16'h0124; mem[5]  = 16'h1135; mem[6]  = 16'h2136; mem[7]  = 16'h3137;
    mem[8]  = 16'h4218; mem[9]  = 16'h4129; mem[10] = 16'h0110; mem[11] = 16'h9A40;
    mem[12] = 16'h9A51; mem[13] = 16'h9A62; mem[14] = 16'h9A73; mem[15] = 16'h9A84;
    mem[16] = 16'h9A95; mem[17] = 16'h9A06; mem[18] = 16'hA127; mem[19] = 16'hA332;
    mem[20] = 16'h9A17; mem[21] = 16'h9A17; mem[22] = 16'hB01E;
    for (int i = 23; i < 30; i++) mem[i] = 16'h9A17;
    mem[30] = 16'h5FFF; mem[31] = 16'hA00F;
    mem[246] = 16'hAAAA; mem[247] = 16'h1234;
    mem[248] = 16'h0005; mem[249] = 16'hFFF9; mem[250] = 16'h0003; mem[251] = 16'h00F0;
    for (int i = 0; i < 256; i++) rmem[i] = mem[i];
    for (int i = 0; i < 16; i++) rreg[i] = 16'h0000;
    rpc = 16'h0000;

    repeat (3) begin
      @(negedge clk);
      chk(mem_addr == 16'h0 && mem_we == 1'b0, "R1 reset", mem_addr, 16'h0);
    end
    @(negedge clk);
    rst = 1'b0;
    #1;
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (expq.size() == 0) step_model();
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(mem_addr == e[31:16], {t, " R10 addr"}, mem_addr, e[31:16]);
      chk(mem_we == e[32], {t, " R10 we"}, {15'h0, mem_we}, {15'h0, e[32]});
      if (e[32]) chk(mem_wdata == e[15:0], {t, " wdata"}, mem_wdata, e[15:0]);
      @(negedge clk);
      #1;
    end

    chk(mem[240] == 16'hFFFE, "R3 add",  mem[240], 16'hFFFE);
    chk(mem[241] == 16'h0001, "R3 and",  mem[241], 16'h0001);
    chk(mem[242] == 16'h0007, "R3 or",   mem[242], 16'h0007);
    chk(mem[243] == 16'h0002, "R3 sub",  mem[243], 16'h0002);
    chk(mem[244] == 16'h0001, "R3 slt true",  mem[244], 16'h0001);
    chk(mem[245] == 16'h0000, "R3 slt false", mem[245], 16'h0000);
    chk(mem[246] == 16'h0000, "R8 zero register", mem[246], 16'h0000);
    chk(mem[247] == 16'h1234, "R6 R7 skipped stores", mem[247], 16'h1234);
    chk(mem[30]  == 16'h5FFF, "R9 no side effect", mem[30], 16'h5FFF);
    for (int i = 0; i < 256; i++)
      chk(mem[i] == rmem[i], "R4 R5 memory image", mem[i], rmem[i]);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule